// File: doc/BRIEF.md
# Shadow Register Update Controller

This block keeps a staged (shadow) copy and a live (working) copy of the timing values that a PWM timer consumes: counter reload, counter start, the force-output command word, and one compare value per comparator. Software writes only the shadow copies. Each group of registers has its own configurable moment at which the shadow copy is moved into the working copy, so that a new period, duty cycle or force pattern takes effect on a well-defined timer boundary and not midway through a cycle.

The shadow registers are write-protected. A write of the 32-bit unlock key opens them. Any other value written to the key address closes them again. Issuing a software lock event closes them too, and the same event loads every group whose trigger is the lock event. When double-write locking is enabled, the lock command has to be written twice before the event is issued.

The timer counter and the comparators sit outside this block. It sees their compare outputs and capture inputs as level signals and finds the edges itself. It also receives a reload strobe and a synchronisation strobe. Comparator select fields are three bits wide and are taken modulo `NUM_CMP`, which must be a power of two no larger than 8.

Top module: `shadow_update_ctrl`

## Requirements
- R1: After reset all shadow and working values are zero, the configuration is zero, and `locked_o` is 1.
- R2: Writing 0xB0382607 to address 0 makes `locked_o` 0 from the next cycle. Writing any other value to address 0 makes `locked_o` 1.
- R3: While `locked_o` is 1, writes to the shadow addresses (3 reload, 4 start, 5 force, 8+i compare i) are ignored. The configuration register at address 2 and the lock command at address 1 are never protected.
- R4: The counter group (reload and start) loads according to cfg[1:0]: 0 on the lock event, 1 in the same cycle as its own shadow write, 2 on the selected comparator edge, 3 on `sync_in`.
- R5: For the counter group, cfg[4:2] selects the `cmp_level` bit and cfg[5] selects the edge (0 rising, 1 falling). Edges on other comparators, and edges of the other direction, do not load.
- R6: The force group loads according to cfg[7:6]: 0 on `reload_stb`, 1 on its own write, 2 on the edge of `cmp_level[cfg[10:8]]` chosen by cfg[11] (0 rising, 1 falling), 3 on `sync_in`.
- R7: The compare group loads according to cfg[13:12]: 0 on the lock event, 1 on its own write, 2 on the edge of `cap_level[cfg[16:14]]` chosen by cfg[17] (0 rising, 1 falling), 3 on `reload_stb`.
- R8: Writing address 1 with bit 0 set issues the lock event when cfg[18] is 0. When cfg[18] is 1, the first such write only arms the lock and the second issues it. Writing address 1 with bit 0 clear disarms. A lock event sets `locked_o`.
- R9: When a load trigger and an accepted shadow write fall in the same cycle, the working register receives the newly written value.
- R10: A working register keeps its value in every cycle in which its group's selected trigger does not occur, including cycles in which one of the unselected triggers fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| cmp_level | input | NUM_CMP | Comparator output levels |
| cap_level | input | NUM_CMP | Capture input levels |
| reload_stb | input | 1 | Counter reload pulse |
| sync_in | input | 1 | Shadow synchronisation pulse |
| reload_q | output | CNT_W | Working reload value |
| start_q | output | CNT_W | Working start value |
| force_q | output | FRC_W | Working force command |
| cmp_q | output | NUM_CMP*CNT_W | Working compare values, comparator i at bits i*CNT_W upward |
| locked_o | output | 1 | Shadow write protection active |

## Verification
The assertions check the following on every cycle:
- a protected write never moves a working value;
- an immediate-mode write lands on the very next cycle;
- a rejected key always closes protection, and a lock event always closes it;
- the first write in double-write mode never issues the event;
- the edge pickers stay quiet on steady inputs;
- a slot loaded together with a write takes the fresh data.

Only the bench scenarios show which trigger source each configuration field selects. That takes a sweep over every comparator index and both edge polarities for the counter group, plus the double-write arm and disarm sequence and the interaction of the lock event with several groups at once.

// File: rtl/shadow_update_pkg.sv
package shadow_update_pkg;

  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned SEL_SPAN = 1 << SEL_W;

  localparam logic [31:0] UNLOCK_KEY = 32'hB038_2607;

  localparam logic [ADDR_W-1:0] ADR_KEY    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_LOCK   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CFG    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_START  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_FORCE  = 4'd5;
  localparam int unsigned       ADR_CMP_BASE = 8;

  // trigger code 1 always means "load together with the group's own write"
  localparam logic [1:0] TRIG_WRITE = 2'd1;

  typedef struct packed {
    logic             lock_dbl;   // [18]
    logic             cap_edge;   // [17]
    logic [SEL_W-1:0] cap_sel;    // [16:14]
    logic [1:0]       cmp_trig;   // [13:12]
    logic             frc_edge;   // [11]
    logic [SEL_W-1:0] frc_sel;    // [10:8]
    logic [1:0]       frc_trig;   // [7:6]
    logic             cnt_edge;   // [5]
    logic [SEL_W-1:0] cnt_sel;    // [4:2]
    logic [1:0]       cnt_trig;   // [1:0]
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/sru_key_lock.sv
module sru_key_lock
  import shadow_update_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_stb,
  input  logic [31:0] key_data,
  input  logic        lock_stb,
  input  logic        lock_bit,
  input  logic        dbl_en,
  output logic        unlocked_o,
  output logic        lock_evt_o
);

  logic unlocked_q, unlocked_d;
  logic armed_q, armed_d;
  logic evt_w;

  always_comb begin
    evt_w      = lock_stb && lock_bit && (!dbl_en || armed_q);
    armed_d    = armed_q;
    if (lock_stb) begin
      armed_d = lock_bit && dbl_en && !armed_q;
    end
    unlocked_d = unlocked_q;
    if (key_stb) begin
      unlocked_d = (key_data == UNLOCK_KEY);
    end else if (evt_w) begin
      unlocked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (key_stb || evt_w) unlocked_q <= unlocked_d;
      if (lock_stb)         armed_q    <= armed_d;
    end
  end

  assign unlocked_o = unlocked_q;
  assign lock_evt_o = evt_w;

  // R2: a rejected key value always leaves protection closed
  a_r2_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (key_stb && key_data != UNLOCK_KEY) |=> !unlocked_o);

  // R8: the lock event always closes protection
  a_r8_event_closes: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt_o |=> !unlocked_o);

  // R8: in double-write mode an unarmed command never issues the event
  a_r8_first_write_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_en && lock_stb && lock_bit && !armed_q) |-> !lock_evt_o);

endmodule

// File: rtl/sru_edge_pick.sv
module sru_edge_pick
  import shadow_update_pkg::*;
#(
  parameter int unsigned N = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     lvl,
  input  logic [SEL_W-1:0] sel,
  input  logic             falling,
  output logic             evt_o
);

  logic [N-1:0]        prev_q;
  logic [N-1:0]        rise_w, fall_w;
  logic [SEL_SPAN-1:0] rise_ext, fall_ext;
  logic                warm_q;

  always_comb begin
    rise_w = lvl & ~prev_q;
    fall_w = prev_q & ~lvl;
  end

  // select values wrap modulo N (N is a power of two)
  for (genvar j = 0; j < SEL_SPAN; j++) begin : g_wrap
    assign rise_ext[j] = rise_w[j % N];
    assign fall_ext[j] = fall_w[j % N];
  end

  assign evt_o = falling ? fall_ext[sel] : rise_ext[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      warm_q <= 1'b1;
    end
  end

  // R5: no edge is reported while every input holds its level
  a_r5_steady_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q && $stable(lvl)) |-> !evt_o);

endmodule

// File: rtl/sru_shadow_slot.sv
module sru_shadow_slot
  import shadow_update_pkg::*;
#(
  parameter int unsigned W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_val,
  input  logic [1:0]   mode,
  input  logic [3:0]   evt,
  output logic [W-1:0] work_o
);

  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] work_q, work_d;
  logic         load_w;

  always_comb begin
    load_w   = (mode == TRIG_WRITE) ? wr_stb : evt[mode];
    shadow_d = wr_stb ? wr_val : shadow_q;
    work_d   = shadow_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      work_q   <= '0;
    end else begin
      if (wr_stb) shadow_q <= shadow_d;
      if (load_w) work_q   <= work_d;
    end
  end

  assign work_o = work_q;

  // R9: a load coinciding with a write transfers the written data
  a_r9_fresh_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && load_w) |=> work_q == $past(wr_val));

  // R10: after any load the working copy matches the staged copy
  a_r10_work_matches_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> work_q == shadow_q);

endmodule

// File: rtl/shadow_update_ctrl.sv
module shadow_update_ctrl
  import shadow_update_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned FRC_W   = 16,
  parameter int unsigned NUM_CMP = 4
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic [NUM_CMP-1:0]       cmp_level,
  input  logic [NUM_CMP-1:0]       cap_level,
  input  logic                     reload_stb,
  input  logic                     sync_in,
  output logic [CNT_W-1:0]         reload_q,
  output logic [CNT_W-1:0]         start_q,
  output logic [FRC_W-1:0]         force_q,
  output logic [NUM_CMP*CNT_W-1:0] cmp_q,
  output logic                     locked_o
);

  // reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // configuration register (never write-protected)
  cfg_t cfg_q, cfg_d;
  logic key_stb, lock_stb, cfg_stb;
  logic unlocked, lock_evt;
  logic rld_wr, sta_wr, frc_wr;
  logic [NUM_CMP-1:0] cmp_wr;

  always_comb begin
    key_stb  = wr_en && (wr_addr == ADR_KEY);
    lock_stb = wr_en && (wr_addr == ADR_LOCK);
    cfg_stb  = wr_en && (wr_addr == ADR_CFG);
    rld_wr   = wr_en && unlocked && (wr_addr == ADR_RELOAD);
    sta_wr   = wr_en && unlocked && (wr_addr == ADR_START);
    frc_wr   = wr_en && unlocked && (wr_addr == ADR_FORCE);
    cfg_d    = cfg_t'(wr_data[CFG_W-1:0]);
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_dec
    assign cmp_wr[i] = wr_en && unlocked && (wr_addr == ADDR_W'(ADR_CMP_BASE + i));
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cfg_q <= '0;
    else if (cfg_stb) cfg_q <= cfg_d;
  end

  sru_key_lock u_key_lock (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .key_stb    (key_stb),
    .key_data   (wr_data),
    .lock_stb   (lock_stb),
    .lock_bit   (wr_data[0]),
    .dbl_en     (cfg_q.lock_dbl),
    .unlocked_o (unlocked),
    .lock_evt_o (lock_evt)
  );

  assign locked_o = !unlocked;

  // hardware event pickers
  logic cnt_hw_evt, frc_hw_evt, cap_evt;

  sru_edge_pick #(.N(NUM_CMP)) u_cnt_pick (
    .clk(clk), .rst_n(rst_sync_n), .lvl(cmp_level),
    .sel(cfg_q.cnt_sel), .falling(cfg_q.cnt_edge), .evt_o(cnt_hw_evt)
  );

  sru_edge_pick #(.N(NUM_CMP)) u_frc_pick (
    .clk(clk), .rst_n(rst_sync_n), .lvl(cmp_level),
    .sel(cfg_q.frc_sel), .falling(cfg_q.frc_edge), .evt_o(frc_hw_evt)
  );

  sru_edge_pick #(.N(NUM_CMP)) u_cap_pick (
    .clk(clk), .rst_n(rst_sync_n), .lvl(cap_level),
    .sel(cfg_q.cap_sel), .falling(cfg_q.cap_edge), .evt_o(cap_evt)
  );

  // per-group source vectors, indexed by the trigger code (code 1 unused here)
  logic [3:0] cnt_src, frc_src, cmp_src;
  assign cnt_src = {sync_in,    cnt_hw_evt, 1'b0, lock_evt};
  assign frc_src = {sync_in,    frc_hw_evt, 1'b0, reload_stb};
  assign cmp_src = {reload_stb, cap_evt,    1'b0, lock_evt};

  sru_shadow_slot #(.W(CNT_W)) u_reload (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(rld_wr), .wr_val(wr_data[CNT_W-1:0]),
    .mode(cfg_q.cnt_trig), .evt(cnt_src), .work_o(reload_q)
  );

  sru_shadow_slot #(.W(CNT_W)) u_start (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(sta_wr), .wr_val(wr_data[CNT_W-1:0]),
    .mode(cfg_q.cnt_trig), .evt(cnt_src), .work_o(start_q)
  );

  sru_shadow_slot #(.W(FRC_W)) u_force (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(frc_wr), .wr_val(wr_data[FRC_W-1:0]),
    .mode(cfg_q.frc_trig), .evt(frc_src), .work_o(force_q)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    sru_shadow_slot #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_sync_n), .wr_stb(cmp_wr[i]), .wr_val(wr_data[CNT_W-1:0]),
      .mode(cfg_q.cmp_trig), .evt(cmp_src), .work_o(cmp_q[i*CNT_W +: CNT_W])
    );
  end

  // R3: a protected write in immediate mode leaves the working reload alone
  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (locked_o && wr_en && wr_addr == ADR_RELOAD && cfg_q.cnt_trig == TRIG_WRITE)
    |=> $stable(reload_q));

  // R4: an accepted start write in immediate mode appears on the next cycle
  a_r4_immediate_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!locked_o && wr_en && wr_addr == ADR_START && cfg_q.cnt_trig == TRIG_WRITE)
    |=> start_q == $past(wr_data[CNT_W-1:0]));

endmodule

// File: tb/shadow_update_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_update_ctrl_bench;
  import shadow_update_pkg::*;

  localparam int unsigned CW = 16;
  localparam int unsigned FW = 16;
  localparam int unsigned NC = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      wr_addr;
  logic [31:0]     wr_data;
  logic [NC-1:0]   cmp_level;
  logic [NC-1:0]   cap_level;
  logic            reload_stb;
  logic            sync_in;
  logic [CW-1:0]   reload_q, start_q;
  logic [FW-1:0]   force_q;
  logic [NC*CW-1:0] cmp_q;
  logic            locked_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  shadow_update_ctrl #(.CNT_W(CW), .FRC_W(FW), .NUM_CMP(NC)) u_shadow_update_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_level(cmp_level), .cap_level(cap_level), .reload_stb(reload_stb), .sync_in(sync_in),
    .reload_q(reload_q), .start_q(start_q), .force_q(force_q), .cmp_q(cmp_q), .locked_o(locked_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cmp(input int i, input logic v);
    @(negedge clk); cmp_level[i] = v; @(negedge clk);
  endtask

  task automatic set_cap(input int i, input logic v);
    @(negedge clk); cap_level[i] = v; @(negedge clk);
  endtask

  task automatic pulse_sync;
    @(negedge clk); sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic pulse_reload;
    @(negedge clk); reload_stb = 1'b1; @(negedge clk); reload_stb = 1'b0;
  endtask

  function automatic logic [31:0] mkcfg(input int ct, input int cs, input int ce,
                                        input int ft, input int fs, input int fe,
                                        input int mt, input int ps, input int pe,
                                        input int dbl);
    return 32'(ct) | (32'(cs) << 2) | (32'(ce) << 5) | (32'(ft) << 6) | (32'(fs) << 8)
         | (32'(fe) << 11) | (32'(mt) << 12) | (32'(ps) << 14) | (32'(pe) << 17)
         | (32'(dbl) << 18);
  endfunction

  function automatic logic [31:0] cmpv(input int i);
    return 32'(cmp_q[i*CW +: CW]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_rld;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cmp_level = '0; cap_level = '0; reload_stb = 1'b0; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reload", 32'(reload_q), 0);
    chk("R1 start",  32'(start_q), 0);
    chk("R1 force",  32'(force_q), 0);
    for (int i = 0; i < NC; i++) chk("R1 cmp", cmpv(i), 0);
    chk("R1 locked", 32'(locked_o), 1);

    // everything immediate; protected writes ignored
    wr(ADR_CFG, mkcfg(1,0,0, 1,0,0, 1,0,0, 0));
    wr(ADR_RELOAD, 32'h1234);  chk("R3 reload locked", 32'(reload_q), 0);
    wr(ADR_FORCE, 32'h00AA);   chk("R3 force locked", 32'(force_q), 0);
    wr(4'd10, 32'h0055);       chk("R3 cmp2 locked", cmpv(2), 0);

    // R2 key handling
    wr(ADR_KEY, 32'hB038_2606); chk("R2 wrong key", 32'(locked_o), 1);
    wr(ADR_KEY, UNLOCK_KEY);    chk("R2 right key", 32'(locked_o), 0);
    wr(ADR_RELOAD, 32'h1234);  chk("R4 immediate reload", 32'(reload_q), 32'h1234);
    wr(ADR_FORCE, 32'h00AA);   chk("R6 immediate force", 32'(force_q), 32'h00AA);
    wr(4'd10, 32'h0055);       chk("R7 immediate cmp2", cmpv(2), 32'h0055);
    wr(ADR_KEY, 32'h0);        chk("R2 relock", 32'(locked_o), 1);
    wr(ADR_START, 32'h9999);   chk("R3 start locked", 32'(start_q), 0);
    wr(ADR_KEY, UNLOCK_KEY);

    // R5 sweep: every comparator select and both edges for the counter group
    exp_rld = 32'h1234;
    for (int s = 0; s < NC; s++) begin
      for (int e = 0; e < 2; e++) begin
        logic st;
        int u;
        logic [31:0] v;
        st = (e == 0);
        u  = (s + 1) % NC;
        v  = 32'h100 + 32'(s*2 + e);
        @(negedge clk); cmp_level = {NC{st}}; @(negedge clk);
        wr(ADR_CFG, mkcfg(2,s,e, 1,0,0, 1,0,0, 0));
        wr(ADR_RELOAD, v);
        chk("R4 hw wait", 32'(reload_q), exp_rld);
        set_cmp(u, !st); set_cmp(u, st);
        chk("R10 other comparator", 32'(reload_q), exp_rld);
        set_cmp(s, !st);
        chk("R5 wrong edge", 32'(reload_q), exp_rld);
        pulse_sync;
        chk("R10 sync unselected", 32'(reload_q), exp_rld);
        set_cmp(s, st);
        chk("R5 selected edge", 32'(reload_q), v);
        exp_rld = v;
      end
    end

    // R4 sync trigger
    wr(ADR_CFG, mkcfg(3,0,0, 1,0,0, 1,0,0, 0));
    wr(ADR_START, 32'h4321);   chk("R4 sync wait", 32'(start_q), 0);
    pulse_sync;                chk("R4 sync load", 32'(start_q), 32'h4321);

    // R9 write and trigger in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_RELOAD; wr_data = 32'h7777; sync_in = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sync_in = 1'b0;
    chk("R9 same cycle", 32'(reload_q), 32'h7777);

    // R8 single-write lock event
    wr(ADR_CFG, mkcfg(0,0,0, 1,0,0, 1,0,0, 0));
    wr(ADR_RELOAD, 32'h2222);  chk("R4 lock wait", 32'(reload_q), 32'h7777);
    wr(ADR_LOCK, 32'h1);
    chk("R8 single issue", 32'(reload_q), 32'h2222);
    chk("R8 single relocks", 32'(locked_o), 1);

    // R8 double-write lock event
    wr(ADR_KEY, UNLOCK_KEY);
    wr(ADR_CFG, mkcfg(0,0,0, 1,0,0, 0,0,0, 1));
    wr(4'd9, 32'h3333);        chk("R7 lock wait", cmpv(1), 0);
    wr(ADR_RELOAD, 32'h4444);
    wr(ADR_LOCK, 32'h1);
    chk("R8 first write only arms", 32'(reload_q), 32'h2222);
    chk("R8 still unlocked", 32'(locked_o), 0);
    wr(ADR_LOCK, 32'h1);
    chk("R8 second write issues", 32'(reload_q), 32'h4444);
    chk("R7 lock event cmp1", cmpv(1), 32'h3333);
    chk("R8 double relocks", 32'(locked_o), 1);

    // R8 disarm
    wr(ADR_KEY, UNLOCK_KEY);
    wr(ADR_RELOAD, 32'h5555);
    wr(ADR_LOCK, 32'h1);
    wr(ADR_LOCK, 32'h0);
    wr(ADR_LOCK, 32'h1);
    chk("R8 disarmed", 32'(reload_q), 32'h4444);
    chk("R8 disarmed unlocked", 32'(locked_o), 0);
    wr(ADR_LOCK, 32'h1);
    chk("R8 rearmed issue", 32'(reload_q), 32'h5555);

    // R6 force group
    wr(ADR_KEY, UNLOCK_KEY);
    wr(ADR_CFG, mkcfg(1,0,0, 0,0,0, 1,0,0, 0));
    wr(ADR_FORCE, 32'h0F0F);   chk("R6 reload wait", 32'(force_q), 32'h00AA);
    pulse_reload;              chk("R6 reload load", 32'(force_q), 32'h0F0F);
    set_cmp(3, 1'b1);
    wr(ADR_CFG, mkcfg(1,0,0, 2,3,1, 1,0,0, 0));
    wr(ADR_FORCE, 32'h00F0);   chk("R6 hw wait", 32'(force_q), 32'h0F0F);
    set_cmp(3, 1'b0);          chk("R6 falling cmp3", 32'(force_q), 32'h00F0);
    wr(ADR_CFG, mkcfg(1,0,0, 3,0,0, 1,0,0, 0));
    wr(ADR_FORCE, 32'hABCD);   chk("R10 force wait", 32'(force_q), 32'h00F0);
    pulse_reload;              chk("R10 reload unselected", 32'(force_q), 32'h00F0);
    pulse_sync;                chk("R6 sync load", 32'(force_q), 32'hABCD);

    // R7 compare group
    wr(ADR_CFG, mkcfg(1,0,0, 1,0,0, 2,1,0, 0));
    wr(4'd11, 32'h0303);       chk("R7 cap wait", cmpv(3), 0);
    set_cap(2, 1'b1);          chk("R7 other capture", cmpv(3), 0);
    set_cap(1, 1'b1);          chk("R7 capture rise", cmpv(3), 32'h0303);
    chk("R7 cmp1 kept", cmpv(1), 32'h3333);
    wr(ADR_CFG, mkcfg(1,0,0, 1,0,0, 3,0,0, 0));
    wr(4'd8, 32'h0A0A);        chk("R7 reload wait", cmpv(0), 0);
    pulse_reload;              chk("R7 reload load", cmpv(0), 32'h0A0A);
    wr(ADR_CFG, mkcfg(1,0,0, 1,0,0, 2,2,1, 0));
    wr(4'd8, 32'h0B0B);        chk("R7 fall wait", cmpv(0), 32'h0A0A);
    set_cap(2, 1'b0);          chk("R7 capture fall", cmpv(0), 32'h0B0B);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule